// File: doc/BRIEF.md
# Issued Micro-op Response Matcher

This block owns the issue handshake for a group of issue queue slots. Each cycle the queue control presents, per dequeue port, a one-hot pick over all slots plus a ready bit. A slot picked on a ready port is not freed. It is flagged as in flight, notes which of the two ports carried it, and starts a small timer. The timer counts the cycles since the micro-op left.

Two operand-stage response channels come back per port. The first-stage channel arrives one cycle after issue and the second-stage channel one cycle later. Each response carries a reorder-buffer index and a pass/fail bit. A slot accepts a response only when all of the following agree with the response: the recorded port, the timer value for that stage, and the slot's own reorder index. Matching does not use slot position, so a slot that is rewritten elsewhere keeps no stale claim. A pass retires the slot. A fail drops the in-flight flag, and the micro-op can then be picked again.

The block also forms the dequeued micro-op for each port. The slots fall into three tiers: enqueue, simple and complex. The control provides one oldest-candidate one-hot per tier and port. The complex candidate wins over the simple one, and the simple one wins over the enqueue one.

Top module: `iq_issue_resp`

## Requirements
- R1: While reset is held and after its release, every slot reads not valid and not in flight.
- R2: A slot write sets the slot valid and not in flight, and stores its reorder index and payload. It takes priority over any response or dequeue aimed at that slot in the same cycle.
- R3: A slot that is valid and not in flight becomes in flight on the next edge when its bit in the port-p select (bit p*NUM_SLOTS+i) is high and ready[p] is high. A select with ready low has no effect. When both ports pick the same slot, port 0 is recorded.
- R4: The issue timer reads 0 in the first cycle after dequeue, rises by one each later cycle and holds at 3. A response whose stage does not match the timer (stage 0 needs 0, stage 1 needs 1) is ignored.
- R5: A response on port p reaches a slot only if the slot is in flight, its recorded port is p and the response reorder index equals the slot's index. A response on the other port, or one with a different index, leaves the slot unchanged.
- R6: A delivered pass response makes the slot not valid on the next edge. A delivered fail response clears the in-flight flag, keeps the slot valid, and lets it be dequeued again.
- R7: Flush clears valid and in-flight for every slot on the next edge, overriding writes, responses and dequeues.
- R8: Slots 0..NUM_ENQ-1 are the enqueue tier, the next NUM_SIMP are the simple tier and the rest are the complex tier. Bit k of a tier's oldest one-hot names the k-th slot of that tier. Per port, the output takes the complex candidate first, then simple, then enqueue, with tier code 2, 1 or 0 and that slot's index and payload. With no candidate, valid, tier, index and payload are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear all slots |
| wr_en | input | NUM_SLOTS | Per-slot write strobe |
| wr_rob | input | NUM_SLOTS*ROB_W | Per-slot reorder index to write |
| wr_pay | input | NUM_SLOTS*PAY_W | Per-slot payload to write |
| deq_sel | input | 2*NUM_SLOTS | One-hot slot pick per port, port p at bits p*NUM_SLOTS+: |
| deq_ready | input | 2 | Per-port dequeue ready |
| rsp0_valid | input | 2 | First-stage response present, per port |
| rsp0_pass | input | 2 | First-stage response pass (1) or fail (0) |
| rsp0_rob | input | 2*ROB_W | First-stage response reorder index, per port |
| rsp1_valid | input | 2 | Second-stage response present, per port |
| rsp1_pass | input | 2 | Second-stage response pass (1) or fail (0) |
| rsp1_rob | input | 2*ROB_W | Second-stage response reorder index, per port |
| enq_oldest | input | 2*NUM_ENQ | Oldest enqueue-tier candidate per port, one-hot |
| simp_oldest | input | 2*NUM_SIMP | Oldest simple-tier candidate per port, one-hot |
| comp_oldest | input | 2*NUM_COMP | Oldest complex-tier candidate per port, one-hot |
| slot_valid | output | NUM_SLOTS | Slot holds a micro-op |
| slot_issued | output | NUM_SLOTS | Slot micro-op is in flight |
| out_valid | output | 2 | Dequeued micro-op present, per port |
| out_tier | output | 4 | Tier of dequeued micro-op, 2 bits per port |
| out_rob | output | 2*ROB_W | Reorder index of dequeued micro-op |
| out_pay | output | 2*PAY_W | Payload of dequeued micro-op |

## Verification
Several events can land in one cycle. A response can retire or release one micro-op while a new dequeue marks another slot on the same port. Both stage responses can also arrive together for two different micro-ops, told apart only by their timers. Random traffic produces these overlaps often: responses carry indices taken from live slots, and picks and ready bits are random. A bench-side model holds the expected slot state and is compared every cycle. Directed sequences pin down timer mismatches, wrong-port and wrong-index responses, and a flush that lands together with a write and a response.

// File: rtl/iqr_pkg.sv
// Shared types for the issued micro-op response matcher.
// Assumes exactly two dequeue ports, so a recorded port fits in one bit.
package iqr_pkg;
    localparam int NUM_PORTS = 2;
    localparam int TIMER_W   = 2;
    localparam logic [TIMER_W-1:0] TIMER_MAX = 2'd3;

    localparam logic [1:0] TIER_ENQ  = 2'd0;
    localparam logic [1:0] TIER_SIMP = 2'd1;
    localparam logic [1:0] TIER_COMP = 2'd2;

    // Control state held by one slot
    typedef struct packed {
        logic               valid;
        logic               issued;
        logic               port;
        logic [TIMER_W-1:0] timer;
    } slot_ctl_t;
endpackage

// File: rtl/iqr_slot.sv
// One issue queue slot: holds a micro-op, tracks its in-flight state,
// the port it left through and the cycles since it left.
// Assumes a response is only presented to an in-flight slot and a
// dequeue only acts on a valid slot that is not in flight.
module iqr_slot
    import iqr_pkg::*;
#(
    parameter int ROB_W = 6,
    parameter int PAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [ROB_W-1:0] wr_rob,
    input  logic [PAY_W-1:0] wr_pay,
    input  logic             deq_hit,
    input  logic             deq_port,
    input  logic             resp_hit,
    input  logic             resp_pass,
    output slot_ctl_t        ctl,
    output logic [ROB_W-1:0] rob,
    output logic [PAY_W-1:0] pay
);
    // Control state update: flush > write > response > dequeue > timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (flush) begin
            ctl.valid  <= 1'b0;
            ctl.issued <= 1'b0;
        end else if (wr_en) begin
            ctl.valid  <= 1'b1;
            ctl.issued <= 1'b0;
            ctl.port   <= 1'b0;
            ctl.timer  <= '0;
        end else if (resp_hit) begin
            ctl.issued <= 1'b0;
            if (resp_pass) begin
                ctl.valid <= 1'b0;
            end
        end else if (deq_hit && ctl.valid && !ctl.issued) begin
            ctl.issued <= 1'b1;
            ctl.port   <= deq_port;
            ctl.timer  <= '0;
        end else if (ctl.issued && (ctl.timer != TIMER_MAX)) begin
            ctl.timer <= ctl.timer + 1'b1;
        end
    end

    // Micro-op data capture on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rob <= '0;
            pay <= '0;
        end else if (wr_en && !flush) begin
            rob <= wr_rob;
            pay <= wr_pay;
        end
    end
endmodule

// File: rtl/iqr_resp_route.sv
// Decides whether a stage response belongs to one slot.
// Matching uses the recorded port, the issue timer and the reorder index,
// never the slot position. Stage 0 expects timer 0, stage 1 timer 1.
module iqr_resp_route
    import iqr_pkg::*;
#(
    parameter int ROB_W = 6
) (
    input  slot_ctl_t                  ctl,
    input  logic [ROB_W-1:0]           rob,
    input  logic [NUM_PORTS-1:0]       rsp0_valid,
    input  logic [NUM_PORTS-1:0]       rsp0_pass,
    input  logic [NUM_PORTS*ROB_W-1:0] rsp0_rob,
    input  logic [NUM_PORTS-1:0]       rsp1_valid,
    input  logic [NUM_PORTS-1:0]       rsp1_pass,
    input  logic [NUM_PORTS*ROB_W-1:0] rsp1_rob,
    output logic                       hit,
    output logic                       pass
);
    logic [ROB_W-1:0] rob0_sel;
    logic [ROB_W-1:0] rob1_sel;
    logic             hit0;
    logic             hit1;
    logic             live;

    // Pick the response channel of the port this slot left through
    always_comb begin
        rob0_sel = ctl.port ? rsp0_rob[2*ROB_W-1:ROB_W] : rsp0_rob[ROB_W-1:0];
        rob1_sel = ctl.port ? rsp1_rob[2*ROB_W-1:ROB_W] : rsp1_rob[ROB_W-1:0];
    end

    // Compare stage timing and reorder index for each stage
    always_comb begin
        live = ctl.valid && ctl.issued;
        hit0 = live && (ctl.timer == 2'd0) && rsp0_valid[ctl.port] && (rob0_sel == rob);
        hit1 = live && (ctl.timer == 2'd1) && rsp1_valid[ctl.port] && (rob1_sel == rob);
        hit  = hit0 || hit1;
        pass = hit0 ? rsp0_pass[ctl.port] : rsp1_pass[ctl.port];
    end
endmodule

// File: rtl/iqr_deq_pick.sv
// Builds the dequeued micro-op for one port from three per-tier oldest
// one-hot candidates, with complex over simple over enqueue.
// Assumes each tier candidate vector is one-hot or zero.
module iqr_deq_pick
    import iqr_pkg::*;
#(
    parameter int NUM_ENQ  = 2,
    parameter int NUM_SIMP = 2,
    parameter int NUM_COMP = 4,
    parameter int ROB_W    = 6,
    parameter int PAY_W    = 16,
    localparam int NUM_SLOTS = NUM_ENQ + NUM_SIMP + NUM_COMP
) (
    input  logic [NUM_SLOTS*ROB_W-1:0] slot_rob,
    input  logic [NUM_SLOTS*PAY_W-1:0] slot_pay,
    input  logic [NUM_ENQ-1:0]         enq_oh,
    input  logic [NUM_SIMP-1:0]        simp_oh,
    input  logic [NUM_COMP-1:0]        comp_oh,
    output logic                       valid,
    output logic [1:0]                 tier,
    output logic [ROB_W-1:0]           rob,
    output logic [PAY_W-1:0]           pay
);
    localparam int SIMP_BASE = NUM_ENQ;
    localparam int COMP_BASE = NUM_ENQ + NUM_SIMP;

    logic [ROB_W-1:0] enq_rob, simp_rob, comp_rob;
    logic [PAY_W-1:0] enq_pay, simp_pay, comp_pay;

    // AND-OR mux of each tier's candidate
    always_comb begin
        enq_rob  = '0; enq_pay  = '0;
        simp_rob = '0; simp_pay = '0;
        comp_rob = '0; comp_pay = '0;
        for (int k = 0; k < NUM_ENQ; k++) begin
            if (enq_oh[k]) begin
                enq_rob = enq_rob | slot_rob[k*ROB_W +: ROB_W];
                enq_pay = enq_pay | slot_pay[k*PAY_W +: PAY_W];
            end
        end
        for (int k = 0; k < NUM_SIMP; k++) begin
            if (simp_oh[k]) begin
                simp_rob = simp_rob | slot_rob[(SIMP_BASE+k)*ROB_W +: ROB_W];
                simp_pay = simp_pay | slot_pay[(SIMP_BASE+k)*PAY_W +: PAY_W];
            end
        end
        for (int k = 0; k < NUM_COMP; k++) begin
            if (comp_oh[k]) begin
                comp_rob = comp_rob | slot_rob[(COMP_BASE+k)*ROB_W +: ROB_W];
                comp_pay = comp_pay | slot_pay[(COMP_BASE+k)*PAY_W +: PAY_W];
            end
        end
    end

    // Fixed tier priority
    always_comb begin
        valid = 1'b1;
        if (|comp_oh) begin
            tier = TIER_COMP; rob = comp_rob; pay = comp_pay;
        end else if (|simp_oh) begin
            tier = TIER_SIMP; rob = simp_rob; pay = simp_pay;
        end else if (|enq_oh) begin
            tier = TIER_ENQ;  rob = enq_rob;  pay = enq_pay;
        end else begin
            valid = 1'b0; tier = TIER_ENQ; rob = '0; pay = '0;
        end
    end
endmodule

// File: rtl/iq_issue_resp.sv
// Issue handshake for a group of issue queue slots: marks dequeued slots
// as in flight, routes stage responses back by port, timer and reorder
// index, and forms the dequeued micro-op per port by tier priority.
// Assumes two dequeue ports and one-hot select vectors per port.
module iq_issue_resp
    import iqr_pkg::*;
#(
    parameter int NUM_ENQ  = 2,
    parameter int NUM_SIMP = 2,
    parameter int NUM_COMP = 4,
    parameter int ROB_W    = 6,
    parameter int PAY_W    = 16,
    localparam int NUM_SLOTS = NUM_ENQ + NUM_SIMP + NUM_COMP
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [NUM_SLOTS-1:0]       wr_en,
    input  logic [NUM_SLOTS*ROB_W-1:0] wr_rob,
    input  logic [NUM_SLOTS*PAY_W-1:0] wr_pay,
    input  logic [2*NUM_SLOTS-1:0]     deq_sel,
    input  logic [1:0]                 deq_ready,
    input  logic [1:0]                 rsp0_valid,
    input  logic [1:0]                 rsp0_pass,
    input  logic [2*ROB_W-1:0]         rsp0_rob,
    input  logic [1:0]                 rsp1_valid,
    input  logic [1:0]                 rsp1_pass,
    input  logic [2*ROB_W-1:0]         rsp1_rob,
    input  logic [2*NUM_ENQ-1:0]       enq_oldest,
    input  logic [2*NUM_SIMP-1:0]      simp_oldest,
    input  logic [2*NUM_COMP-1:0]      comp_oldest,
    output logic [NUM_SLOTS-1:0]       slot_valid,
    output logic [NUM_SLOTS-1:0]       slot_issued,
    output logic [1:0]                 out_valid,
    output logic [3:0]                 out_tier,
    output logic [2*ROB_W-1:0]         out_rob,
    output logic [2*PAY_W-1:0]         out_pay
);
    logic [NUM_SLOTS-1:0]         resp_hit;
    logic [NUM_SLOTS-1:0]         resp_pass;
    logic [NUM_SLOTS*TIMER_W-1:0] slot_timer;
    logic [NUM_SLOTS*ROB_W-1:0]   slot_rob;
    logic [NUM_SLOTS*PAY_W-1:0]   slot_pay;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        slot_ctl_t ctl;
        logic      pick0;
        logic      pick1;

        // Dequeue decision for this slot; port 0 wins a double pick
        always_comb begin
            pick0 = deq_sel[i] && deq_ready[0];
            pick1 = deq_sel[NUM_SLOTS+i] && deq_ready[1];
        end

        iqr_slot #(.ROB_W(ROB_W), .PAY_W(PAY_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .wr_en     (wr_en[i]),
            .wr_rob    (wr_rob[i*ROB_W +: ROB_W]),
            .wr_pay    (wr_pay[i*PAY_W +: PAY_W]),
            .deq_hit   (pick0 || pick1),
            .deq_port  (!pick0 && pick1),
            .resp_hit  (resp_hit[i]),
            .resp_pass (resp_pass[i]),
            .ctl       (ctl),
            .rob       (slot_rob[i*ROB_W +: ROB_W]),
            .pay       (slot_pay[i*PAY_W +: PAY_W])
        );

        iqr_resp_route #(.ROB_W(ROB_W)) u_route (
            .ctl        (ctl),
            .rob        (slot_rob[i*ROB_W +: ROB_W]),
            .rsp0_valid (rsp0_valid),
            .rsp0_pass  (rsp0_pass),
            .rsp0_rob   (rsp0_rob),
            .rsp1_valid (rsp1_valid),
            .rsp1_pass  (rsp1_pass),
            .rsp1_rob   (rsp1_rob),
            .hit        (resp_hit[i]),
            .pass       (resp_pass[i])
        );

        // Expose slot status
        assign slot_valid[i]                    = ctl.valid;
        assign slot_issued[i]                   = ctl.issued;
        assign slot_timer[i*TIMER_W +: TIMER_W] = ctl.timer;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        iqr_deq_pick #(
            .NUM_ENQ (NUM_ENQ),
            .NUM_SIMP(NUM_SIMP),
            .NUM_COMP(NUM_COMP),
            .ROB_W   (ROB_W),
            .PAY_W   (PAY_W)
        ) u_pick (
            .slot_rob (slot_rob),
            .slot_pay (slot_pay),
            .enq_oh   (enq_oldest[p*NUM_ENQ +: NUM_ENQ]),
            .simp_oh  (simp_oldest[p*NUM_SIMP +: NUM_SIMP]),
            .comp_oh  (comp_oldest[p*NUM_COMP +: NUM_COMP]),
            .valid    (out_valid[p]),
            .tier     (out_tier[p*2 +: 2]),
            .rob      (out_rob[p*ROB_W +: ROB_W]),
            .pay      (out_pay[p*PAY_W +: PAY_W])
        );
    end
endmodule

// File: rtl/iq_issue_resp_chk.sv
// Assertion checker for iq_issue_resp, attached by bind below.
// Observes ports plus the per-slot response decision and timers.
module iq_issue_resp_chk #(
    parameter int NUM_ENQ  = 2,
    parameter int NUM_SIMP = 2,
    parameter int NUM_COMP = 4,
    localparam int NUM_SLOTS = NUM_ENQ + NUM_SIMP + NUM_COMP
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush,
    input logic [NUM_SLOTS-1:0]   wr_en,
    input logic [2*NUM_SLOTS-1:0] deq_sel,
    input logic [1:0]             deq_ready,
    input logic [2*NUM_COMP-1:0]  comp_oldest,
    input logic [NUM_SLOTS-1:0]   slot_valid,
    input logic [NUM_SLOTS-1:0]   slot_issued,
    input logic [1:0]             out_valid,
    input logic [3:0]             out_tier,
    input logic [NUM_SLOTS-1:0]   resp_hit,
    input logic [NUM_SLOTS-1:0]   resp_pass,
    input logic [2*NUM_SLOTS-1:0] slot_timer
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_a
        p_issued_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
            slot_issued[i] |-> slot_valid[i]);

        p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (!slot_valid[i] && !slot_issued[i]));

        p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && wr_en[i]) |=> (slot_valid[i] && !slot_issued[i]));

        p_deq_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && !wr_en[i] && slot_valid[i] && !slot_issued[i] &&
             ((deq_sel[i] && deq_ready[0]) || (deq_sel[NUM_SLOTS+i] && deq_ready[1])))
            |=> (slot_issued[i] && (slot_timer[2*i +: 2] == 2'd0)));

        p_timer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && !wr_en[i] && slot_issued[i] && !resp_hit[i] &&
             (slot_timer[2*i +: 2] != 2'd3))
            |=> (slot_timer[2*i +: 2] == 2'($past(slot_timer[2*i +: 2]) + 2'd1)));

        p_pass_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && !wr_en[i] && resp_hit[i] && resp_pass[i]) |=> !slot_valid[i]);

        p_fail_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && !wr_en[i] && resp_hit[i] && !resp_pass[i])
            |=> (slot_valid[i] && !slot_issued[i]));
    end

    for (genvar p = 0; p < 2; p++) begin : g_p
        p_comp_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (|comp_oldest[p*NUM_COMP +: NUM_COMP]) |-> (out_valid[p] && (out_tier[2*p +: 2] == 2'd2)));
    end
endmodule

bind iq_issue_resp iq_issue_resp_chk #(
    .NUM_ENQ (NUM_ENQ),
    .NUM_SIMP(NUM_SIMP),
    .NUM_COMP(NUM_COMP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .wr_en       (wr_en),
    .deq_sel     (deq_sel),
    .deq_ready   (deq_ready),
    .comp_oldest (comp_oldest),
    .slot_valid  (slot_valid),
    .slot_issued (slot_issued),
    .out_valid   (out_valid),
    .out_tier    (out_tier),
    .resp_hit    (resp_hit),
    .resp_pass   (resp_pass),
    .slot_timer  (slot_timer)
);

// File: tb/iq_issue_resp_bench.sv
`timescale 1ns/1ps
module iq_issue_resp_bench;
    localparam int NE = 2, NS = 2, NC = 4, RW = 6, PW = 16;
    localparam int N  = NE + NS + NC;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            flush;
    logic [N-1:0]    wr_en;
    logic [N*RW-1:0] wr_rob;
    logic [N*PW-1:0] wr_pay;
    logic [2*N-1:0]  deq_sel;
    logic [1:0]      deq_ready;
    logic [1:0]      rsp0_valid, rsp0_pass, rsp1_valid, rsp1_pass;
    logic [2*RW-1:0] rsp0_rob, rsp1_rob;
    logic [2*NE-1:0] enq_oldest;
    logic [2*NS-1:0] simp_oldest;
    logic [2*NC-1:0] comp_oldest;
    logic [N-1:0]    slot_valid, slot_issued;
    logic [1:0]      out_valid;
    logic [3:0]      out_tier;
    logic [2*RW-1:0] out_rob;
    logic [2*PW-1:0] out_pay;

    int checks = 0;
    int failures = 0;

    // Reference state built from the requirements
    logic          m_valid [N];
    logic          m_issued[N];
    logic          m_port  [N];
    logic [1:0]    m_timer [N];
    logic [RW-1:0] m_rob   [N];
    logic [PW-1:0] m_pay   [N];

    always #2.5 clk = ~clk;

    iq_issue_resp #(.NUM_ENQ(NE), .NUM_SIMP(NS), .NUM_COMP(NC), .ROB_W(RW), .PAY_W(PW)) u_iq_issue_resp (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_rob(wr_rob), .wr_pay(wr_pay),
        .deq_sel(deq_sel), .deq_ready(deq_ready),
        .rsp0_valid(rsp0_valid), .rsp0_pass(rsp0_pass), .rsp0_rob(rsp0_rob),
        .rsp1_valid(rsp1_valid), .rsp1_pass(rsp1_pass), .rsp1_rob(rsp1_rob),
        .enq_oldest(enq_oldest), .simp_oldest(simp_oldest), .comp_oldest(comp_oldest),
        .slot_valid(slot_valid), .slot_issued(slot_issued),
        .out_valid(out_valid), .out_tier(out_tier), .out_rob(out_rob), .out_pay(out_pay)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        flush = 0; wr_en = '0; wr_rob = '0; wr_pay = '0; deq_sel = '0; deq_ready = '0;
        rsp0_valid = '0; rsp0_pass = '0; rsp0_rob = '0;
        rsp1_valid = '0; rsp1_pass = '0; rsp1_rob = '0;
        enq_oldest = '0; simp_oldest = '0; comp_oldest = '0;
    endtask

    function automatic logic [N-1:0] pack_valid();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_valid[i];
        return v;
    endfunction

    function automatic logic [N-1:0] pack_issued();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_issued[i];
        return v;
    endfunction

    // Next reference state on a clock edge, from R2..R7
    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            bit h0 = deq_sel[i] && deq_ready[0];
            bit h1 = deq_sel[N+i] && deq_ready[1];
            int p  = int'(m_port[i]);
            bit r0 = m_valid[i] && m_issued[i] && m_timer[i] == 2'd0 &&
                     rsp0_valid[p] && rsp0_rob[p*RW +: RW] == m_rob[i];
            bit r1 = m_valid[i] && m_issued[i] && m_timer[i] == 2'd1 &&
                     rsp1_valid[p] && rsp1_rob[p*RW +: RW] == m_rob[i];
            bit ok = r0 ? rsp0_pass[p] : rsp1_pass[p];
            if (flush) begin
                m_valid[i] = 0; m_issued[i] = 0;
            end else if (wr_en[i]) begin
                m_valid[i] = 1; m_issued[i] = 0; m_port[i] = 0; m_timer[i] = 0;
                m_rob[i] = wr_rob[i*RW +: RW]; m_pay[i] = wr_pay[i*PW +: PW];
            end else if (r0 || r1) begin
                m_issued[i] = 0;
                if (ok) m_valid[i] = 0;
            end else if ((h0 || h1) && m_valid[i] && !m_issued[i]) begin
                m_issued[i] = 1; m_port[i] = !h0; m_timer[i] = 0;
            end else if (m_issued[i] && m_timer[i] != 2'd3) begin
                m_timer[i] = m_timer[i] + 2'd1;
            end
        end
    endtask

    // Expected per-port pick from R8
    task automatic check_pick();
        for (int p = 0; p < 2; p++) begin
            logic v = 0; logic [1:0] t = 0; logic [RW-1:0] r = 0; logic [PW-1:0] y = 0;
            int s = -1;
            for (int k = 0; k < NE; k++) if (enq_oldest[p*NE+k]) begin s = k; t = 2'd0; end
            for (int k = 0; k < NS; k++) if (simp_oldest[p*NS+k]) begin s = NE + k; t = 2'd1; end
            for (int k = 0; k < NC; k++) if (comp_oldest[p*NC+k]) begin s = NE + NS + k; t = 2'd2; end
            if (s >= 0) begin v = 1; r = m_rob[s]; y = m_pay[s]; end
            chk(out_valid[p] == v, "R8 out_valid", 64'(out_valid[p]), 64'(v));
            chk(out_tier[2*p +: 2] == t, "R8 out_tier", 64'(out_tier[2*p +: 2]), 64'(t));
            chk(out_rob[p*RW +: RW] == r && out_pay[p*PW +: PW] == y, "R8 out_rob/pay",
                {out_rob[p*RW +: RW], out_pay[p*PW +: PW]}, {r, y});
        end
    endtask

    task automatic check_state(input string tag);
        chk(slot_valid == pack_valid(), {tag, " slot_valid"}, 64'(slot_valid), 64'(pack_valid()));
        chk(slot_issued == pack_issued(), {tag, " slot_issued"}, 64'(slot_issued), 64'(pack_issued()));
    endtask

    // One clock: inputs already driven after a negedge
    task automatic step(input string tag);
        #1;
        check_pick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic write_slot(input int i, input logic [RW-1:0] r, input logic [PW-1:0] y);
        wr_en[i] = 1'b1; wr_rob[i*RW +: RW] = r; wr_pay[i*PW +: PW] = y;
    endtask

    function automatic logic [7:0] rand_oh(input int size);
        int r = int'($urandom % (size + 1));
        return (r == size) ? 8'd0 : 8'(1 << r);
    endfunction

    task automatic rand_inputs();
        clear_inputs();
        flush = ($urandom % 64) == 0;
        for (int i = 0; i < N; i++) begin
            if (($urandom % 8) == 0) write_slot(i, RW'($urandom), PW'($urandom));
        end
        for (int p = 0; p < 2; p++) begin
            int j0 = int'($urandom % N);
            int j1 = int'($urandom % N);
            if (($urandom % 3) != 0) deq_sel[p*N + int'($urandom % N)] = 1'b1;
            deq_ready[p]  = ($urandom % 4) != 0;
            rsp0_valid[p] = $urandom % 2; rsp0_pass[p] = $urandom % 2;
            rsp0_rob[p*RW +: RW] = m_rob[j0];
            rsp1_valid[p] = $urandom % 2; rsp1_pass[p] = $urandom % 2;
            rsp1_rob[p*RW +: RW] = m_rob[j1];
            enq_oldest[p*NE +: NE]  = rand_oh(NE)[NE-1:0];
            simp_oldest[p*NS +: NS] = rand_oh(NS)[NS-1:0];
            comp_oldest[p*NC +: NC] = rand_oh(NC)[NC-1:0];
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_issued[i] = 0; m_port[i] = 0; m_timer[i] = 0; m_rob[i] = 0; m_pay[i] = 0;
        end
        clear_inputs();
        rst_n = 1'b0;
        write_slot(3, 6'd7, 16'h1234);
        deq_sel[3] = 1'b1; deq_ready = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(slot_valid == '0 && slot_issued == '0, "R1 state in reset", 64'({slot_valid, slot_issued}), 64'd0);
        clear_inputs();
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R2, R3, R5, R4: wrong-port, wrong-stage responses are ignored
        write_slot(4, 6'd5, 16'hC004); step("R2 write");
        clear_inputs(); deq_sel[N+4] = 1'b1; deq_ready = 2'b10; step("R3 dequeue port1");
        chk(slot_issued[4] == 1'b1, "R3 issued after pick", 64'(slot_issued[4]), 64'd1);
        clear_inputs(); rsp0_valid = 2'b01; rsp0_rob[RW-1:0] = 6'd5; rsp0_pass = 2'b00; step("R5 wrong port");
        chk(slot_issued[4] == 1'b1, "R5 other-port response ignored", 64'(slot_issued[4]), 64'd1);
        clear_inputs(); rsp0_valid = 2'b10; rsp0_rob[2*RW-1:RW] = 6'd5; step("R4 stage0 at timer1");
        chk(slot_issued[4] == 1'b1, "R4 stage0 late ignored", 64'(slot_issued[4]), 64'd1);
        clear_inputs(); rsp1_valid = 2'b10; rsp1_pass = 2'b10; rsp1_rob[2*RW-1:RW] = 6'd5; step("R4 stage1 at timer2");
        chk(slot_valid[4] == 1'b1, "R4 stage1 late ignored", 64'(slot_valid[4]), 64'd1);

        // R6: fail releases, reissue, R5 index mismatch, stage1 pass retires
        clear_inputs(); write_slot(5, 6'd9, 16'hC005); step("R2 write");
        clear_inputs(); deq_sel[5] = 1'b1; deq_ready = 2'b01; step("R3 dequeue port0");
        clear_inputs(); rsp0_valid = 2'b01; rsp0_rob[RW-1:0] = 6'd9; step("R6 fail");
        chk(slot_valid[5] && !slot_issued[5], "R6 fail keeps valid, clears issued",
            64'({slot_valid[5], slot_issued[5]}), 64'b10);
        clear_inputs(); deq_sel[5] = 1'b1; deq_sel[N+5] = 1'b1; deq_ready = 2'b11; step("R3 double pick");
        clear_inputs(); rsp0_valid = 2'b01; rsp0_pass = 2'b01; rsp0_rob[RW-1:0] = 6'd8; step("R5 index mismatch");
        chk(slot_valid[5] && slot_issued[5], "R5 mismatched index ignored",
            64'({slot_valid[5], slot_issued[5]}), 64'b11);
        clear_inputs(); rsp1_valid = 2'b01; rsp1_pass = 2'b01; rsp1_rob[RW-1:0] = 6'd9; step("R6 pass");
        chk(slot_valid[5] == 1'b0, "R6 pass retires slot", 64'(slot_valid[5]), 64'd0);

        // R3: select without ready
        clear_inputs(); write_slot(6, 6'd3, 16'hC006); step("R2 write");
        clear_inputs(); deq_sel[6] = 1'b1; deq_ready = 2'b10; step("R3 no ready");
        chk(slot_issued[6] == 1'b0, "R3 pick without ready ignored", 64'(slot_issued[6]), 64'd0);

        // R8: tier priority
        clear_inputs();
        write_slot(0, 6'd10, 16'hE000); write_slot(1, 6'd11, 16'hE001);
        write_slot(2, 6'd12, 16'h5002); write_slot(7, 6'd17, 16'hC007);
        step("R2 write");
        clear_inputs();
        enq_oldest = 4'b1001; simp_oldest = 4'b0001; comp_oldest = 8'b0000_1000;
        #1;
        chk(out_tier[1:0] == 2'd2 && out_pay[PW-1:0] == 16'hC007, "R8 complex over others",
            {out_tier[1:0], out_pay[PW-1:0]}, {2'd2, 16'hC007});
        chk(out_tier[3:2] == 2'd0 && out_pay[2*PW-1:PW] == 16'hE001, "R8 enqueue alone",
            {out_tier[3:2], out_pay[2*PW-1:PW]}, {2'd0, 16'hE001});
        step("R8 pick");

        // R7: flush with write, response and pick in one cycle
        clear_inputs(); deq_sel[7] = 1'b1; deq_ready = 2'b01; step("R3 dequeue");
        clear_inputs(); flush = 1'b1; write_slot(2, 6'd1, 16'h1);
        rsp0_valid = 2'b01; rsp0_pass = 2'b01; rsp0_rob[RW-1:0] = 6'd17;
        deq_sel[0] = 1'b1; deq_ready = 2'b01;
        step("R7 flush");
        chk(slot_valid == '0 && slot_issued == '0, "R7 flush clears all",
            64'({slot_valid, slot_issued}), 64'd0);

        // Random traffic, checked each cycle (R2 R3 R4 R5 R6 R7 R8)
        for (int c = 0; c < 4000; c++) begin
            rand_inputs();
            step("R2 R3 R4 R5 R6 R7 random");
        end
        finish_run();
    end
endmodule